// File: doc/BRIEF.md
# Power Operating Mode Controller

This block holds the power operating mode of a processor and turns it into enables for the clock multiplier (PLL), the core clock and the system clock, plus a select that routes the core clock around the multiplier. There are four modes: full-on, active, sleep and deep sleep. Software requests a new mode at any time, but the request is only held. It takes effect on the cycle the core reports that it is idle, so the switch happens while the core has no work in flight.

Full-on and active may move to any other mode. The two sleep modes have narrow exits. Sleep ends only when a wakeup event arrives on a source that is enabled in the wakeup mask. Sleep then returns to the running mode that entered it. Deep sleep ends only on a real-time-clock interrupt and always resumes in active mode. An asynchronous reset also leaves deep sleep. It enters full-on, or enters active when a boot strap asks for it. Clock synthesis is not part of this block. A divide-by-two of the input clock represents the bypassed core clock, which runs at half the input rate.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is held, mode reads full-on. On the first clock edge after release, mode becomes active (code 1) if `boot_to_active` is high, and otherwise stays full-on (code 0). Mode codes are full-on 0, active 1, sleep 2, deep sleep 3.
- R2: In full-on, `pll_en`, `cclk_en` and `sclk_en` are all 1 and `bypass` is 0.
- R3: In active, `cclk_en`, `sclk_en` and `bypass` are 1 and `pll_en` equals the inverse of `pll_off`. `cclk_half` inverts on every clock edge while the mode stays active.
- R4: In sleep, `cclk_en` is 0 and `sclk_en` is 1. `bypass` and `pll_en` take the values the previous running mode would drive, so the system clock keeps its earlier rate.
- R5: In deep sleep, `pll_en`, `cclk_en`, `sclk_en` and `bypass` are all 0.
- R6: A request with `req_valid` high is stored on the clock edge. The mode does not change until a later edge on which `core_idle` is high. On that edge the mode becomes the stored target.
- R7: From full-on or active, a request for any of the other three modes is legal. A request for the current mode, or any request made while in sleep or deep sleep, is illegal. An illegal request is not stored, and `req_illegal` is high for the one cycle after that edge.
- R8: Sleep is left only on an edge where some bit of `wake_evt` and `wake_mask` is high in both vectors. The controller then returns to the running mode that entered sleep. Unmasked events and `rtc_irq` have no effect in sleep.
- R9: Deep sleep is left only on an edge with `rtc_irq` high, and the next mode is active. Wakeup events have no effect in deep sleep.
- R10: Applying a request consumes it. A later idle edge with no new request leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| boot_to_active | input | 1 | Strap: leave reset into active instead of full-on |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode code |
| core_idle | input | 1 | Core has drained and is idle |
| wake_evt | input | NUM_WAKE | Wakeup event sources |
| wake_mask | input | NUM_WAKE | Per-source wakeup enable |
| rtc_irq | input | 1 | Real-time-clock interrupt |
| pll_off | input | 1 | Turn the PLL off while bypassed |
| mode | output | 2 | Current mode code |
| pll_en | output | 1 | PLL enable |
| cclk_en | output | 1 | Core clock enable |
| sclk_en | output | 1 | System clock enable |
| bypass | output | 1 | Core clock bypasses the PLL |
| cclk_half | output | 1 | Divide-by-two of the input clock standing in for the bypassed core clock |
| req_illegal | output | 1 | One-cycle flag for a rejected request |

## Verification
The assertions assume that `req_mode`, `core_idle`, the wakeup vectors and `rtc_irq` are synchronous to `clk`. They also assume that no request is made on the single boot edge after reset. The stimulus meets both conditions. It changes every input just after a rising edge, it waits out the boot edge before it issues any request, and it holds `req_valid` for exactly one edge. The sweep covers every pair of running start mode and target mode. For the sleep modes it walks a single-bit mask across each wakeup source, with every other source active.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    PM_FULL  = 2'd0,
    PM_ACT   = 2'd1,
    PM_SLEEP = 2'd2,
    PM_DEEP  = 2'd3
  } pm_mode_t;

  function automatic logic pm_is_run(input pm_mode_t m);
    return (m == PM_FULL) || (m == PM_ACT);
  endfunction
endpackage

// File: rtl/pwr_req_latch.sv
module pwr_req_latch
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  pm_mode_t   cur_mode,
  input  logic       apply,
  output logic       pend_vld,
  output pm_mode_t   pend_mode,
  output logic       req_illegal
);
  logic     legal;
  logic     pend_vld_d;
  pm_mode_t pend_mode_d;
  logic     illegal_d;

  always_comb begin
    legal       = pm_is_run(cur_mode) && (pm_mode_t'(req_mode) != cur_mode);
    pend_vld_d  = pend_vld;
    pend_mode_d = pend_mode;
    illegal_d   = 1'b0;
    if (req_valid && legal) begin
      pend_vld_d  = 1'b1;
      pend_mode_d = pm_mode_t'(req_mode);
    end else if (apply) begin
      pend_vld_d  = 1'b0;
    end
    if (req_valid && !legal) illegal_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld    <= 1'b0;
      pend_mode   <= PM_FULL;
      req_illegal <= 1'b0;
    end else begin
      pend_vld    <= pend_vld_d;
      pend_mode   <= pend_mode_d;
      req_illegal <= illegal_d;
    end
  end

  // R7: the flag only follows a request strobe
  p_flag_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_illegal |-> $past(req_valid));

  // R10: an applied request with no new strobe is consumed
  p_pend_consumed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !req_valid) |=> !pend_vld);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int NUM_WAKE = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boot_to_active,
  input  logic                core_idle,
  input  logic                pend_vld,
  input  pm_mode_t            pend_mode,
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  logic [NUM_WAKE-1:0] wake_mask,
  input  logic                rtc_irq,
  output pm_mode_t            mode_q,
  output pm_mode_t            prev_q,
  output logic                apply
);
  logic     boot_q;
  logic     wake;
  pm_mode_t mode_d;
  pm_mode_t prev_d;

  always_comb begin
    wake   = |(wake_evt & wake_mask);
    apply  = !boot_q && pm_is_run(mode_q) && core_idle && pend_vld;
    mode_d = mode_q;
    prev_d = prev_q;
    if (boot_q) begin
      mode_d = boot_to_active ? PM_ACT : PM_FULL;
    end else begin
      unique case (mode_q)
        PM_FULL, PM_ACT: if (apply) begin
          mode_d = pend_mode;
          prev_d = mode_q;
        end
        PM_SLEEP: if (wake) mode_d = prev_q;
        PM_DEEP:  if (rtc_irq) mode_d = PM_ACT;
        default:  mode_d = PM_FULL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      mode_q <= PM_FULL;
      prev_q <= PM_FULL;
    end else begin
      boot_q <= 1'b0;
      mode_q <= mode_d;
      prev_q <= prev_d;
    end
  end

  // R6: a running mode holds without core idle
  p_hold_without_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_q && pm_is_run(mode_q) && !core_idle) |=> $stable(mode_q));

  // R8: sleep holds without an enabled wakeup
  p_sleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_SLEEP && !wake) |=> mode_q == PM_SLEEP);

  // R8: sleep exits only into a running mode
  p_sleep_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_SLEEP && wake) |=> pm_is_run(mode_q));

  // R9: deep sleep holds until the RTC interrupt
  p_deep_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_DEEP && !rtc_irq) |=> mode_q == PM_DEEP);

  // R9: the RTC interrupt resumes in active
  p_deep_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_DEEP && rtc_irq) |=> mode_q == PM_ACT);
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pwr_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pm_mode_t mode_q,
  input  pm_mode_t prev_q,
  input  logic     pll_off,
  output logic     pll_en,
  output logic     cclk_en,
  output logic     sclk_en,
  output logic     bypass,
  output logic     cclk_half
);
  logic     half_d;
  pm_mode_t ref_mode;

  always_comb begin
    ref_mode = (mode_q == PM_SLEEP) ? prev_q : mode_q;
    cclk_en  = pm_is_run(mode_q);
    sclk_en  = (mode_q != PM_DEEP);
    bypass   = sclk_en && (ref_mode == PM_ACT);
    pll_en   = sclk_en && !(bypass && pll_off);
    half_d   = (mode_q == PM_ACT) ? !cclk_half : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cclk_half <= 1'b0;
    else        cclk_half <= half_d;
  end

  // R3: the half-rate clock toggles each cycle in active
  p_half_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PM_ACT && $past(mode_q) == PM_ACT) |-> cclk_half != $past(cclk_half));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NUM_WAKE = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boot_to_active,
  input  logic                req_valid,
  input  logic [1:0]          req_mode,
  input  logic                core_idle,
  input  logic [NUM_WAKE-1:0] wake_evt,
  input  logic [NUM_WAKE-1:0] wake_mask,
  input  logic                rtc_irq,
  input  logic                pll_off,
  output logic [1:0]          mode,
  output logic                pll_en,
  output logic                cclk_en,
  output logic                sclk_en,
  output logic                bypass,
  output logic                cclk_half,
  output logic                req_illegal
);
  pm_mode_t mode_q;
  pm_mode_t prev_q;
  pm_mode_t pend_mode;
  logic     pend_vld;
  logic     apply;

  pwr_req_latch u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_mode    (req_mode),
    .cur_mode    (mode_q),
    .apply       (apply),
    .pend_vld    (pend_vld),
    .pend_mode   (pend_mode),
    .req_illegal (req_illegal)
  );

  pwr_mode_fsm #(.NUM_WAKE(NUM_WAKE)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .boot_to_active (boot_to_active),
    .core_idle      (core_idle),
    .pend_vld       (pend_vld),
    .pend_mode      (pend_mode),
    .wake_evt       (wake_evt),
    .wake_mask      (wake_mask),
    .rtc_irq        (rtc_irq),
    .mode_q         (mode_q),
    .prev_q         (prev_q),
    .apply          (apply)
  );

  pwr_clk_ctrl u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .prev_q    (prev_q),
    .pll_off   (pll_off),
    .pll_en    (pll_en),
    .cclk_en   (cclk_en),
    .sclk_en   (sclk_en),
    .bypass    (bypass),
    .cclk_half (cclk_half)
  );

  assign mode = mode_q;

  // R5: deep sleep leaves every clock stopped
  p_deep_all_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> !(pll_en || cclk_en || sclk_en));

  // R4: sleep stops only the core clock
  p_sleep_sclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (!cclk_en && sclk_en));
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam logic [1:0] M_FULL = 2'd0, M_ACT = 2'd1, M_SLP = 2'd2, M_DEEP = 2'd3;

  logic clk = 1'b0;
  logic rst_n, boot_to_active, req_valid, core_idle, rtc_irq, pll_off;
  logic [1:0] req_mode;
  logic [NW-1:0] wake_evt, wake_mask;
  logic [1:0] mode;
  logic pll_en, cclk_en, sclk_en, bypass, cclk_half, req_illegal;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.NUM_WAKE(NW)) u0 (
    .clk(clk), .rst_n(rst_n), .boot_to_active(boot_to_active),
    .req_valid(req_valid), .req_mode(req_mode), .core_idle(core_idle),
    .wake_evt(wake_evt), .wake_mask(wake_mask), .rtc_irq(rtc_irq),
    .pll_off(pll_off), .mode(mode), .pll_en(pll_en), .cclk_en(cclk_en),
    .sclk_en(sclk_en), .bypass(bypass), .cclk_half(cclk_half),
    .req_illegal(req_illegal)
  );

  // {pll, cclk, sclk, bypass} from R2..R5
  function automatic logic [3:0] exp_outs(logic [1:0] m, logic [1:0] pv, logic po);
    case (m)
      M_FULL:  return 4'b1110;
      M_ACT:   return {!po, 3'b111};
      M_SLP:   return (pv == M_ACT) ? {!po, 3'b011} : 4'b1010;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check_state(string req, logic [1:0] m, logic [1:0] pv);
    check(req, {6'd0, mode}, {6'd0, m});
    check(req, {4'd0, pll_en, cclk_en, sclk_en, bypass}, {4'd0, exp_outs(m, pv, pll_off)});
  endtask

  task automatic do_reset(logic strap);
    rst_n = 1'b0; boot_to_active = strap; req_valid = 1'b0; req_mode = 2'd0;
    core_idle = 1'b0; wake_evt = '0; wake_mask = '0; rtc_irq = 1'b0;
    #(CLK_PERIOD*2);
    check_state("R1 in reset", M_FULL, M_FULL);
    @(posedge clk); #1;
    rst_n = 1'b1;
    tick();
    check_state("R1 boot", strap ? M_ACT : M_FULL, M_FULL);
  endtask

  initial begin
    pll_off = 1'b0;
    for (int f = 0; f < 2; f++) begin
      for (int t = 0; t < 4; t++) begin
        logic [1:0] fm, tm, cur;
        fm = 2'(f); tm = 2'(t);
        pll_off = tm[0] ^ fm[0];
        do_reset(fm[0]);
        req_valid = 1'b1; req_mode = tm;
        tick();
        req_valid = 1'b0;
        check("R7 illegal flag", {7'd0, req_illegal}, {7'd0, (tm == fm)});
        tick();
        check("R7 flag one cycle", {7'd0, req_illegal}, 8'd0);
        check("R6 no idle no change", {6'd0, mode}, {6'd0, fm});
        core_idle = 1'b1;
        tick();
        core_idle = 1'b0;
        cur = (tm == fm) ? fm : tm;
        check_state((tm == fm) ? "R7 illegal ignored" : "R6 applied at idle", cur, fm);
        if (cur == M_ACT) begin
          logic h;
          h = cclk_half;
          tick();
          check("R3 half toggles", {7'd0, cclk_half}, {7'd0, !h});
          h = cclk_half;
          tick();
          check("R3 half toggles", {7'd0, cclk_half}, {7'd0, !h});
        end
        if (cur == M_FULL || cur == M_ACT) begin
          core_idle = 1'b1;
          tick();
          core_idle = 1'b0;
          check("R10 consumed", {6'd0, mode}, {6'd0, cur});
        end
        if (cur == M_SLP) begin
          for (int i = 0; i < NW; i++) begin
            wake_mask = NW'(1) << i;
            wake_evt  = ~wake_mask;
            rtc_irq   = 1'b1;
            tick();
            check_state("R8 unmasked ignored", M_SLP, fm);
          end
          wake_evt = '0; rtc_irq = 1'b0;
          req_valid = 1'b1; req_mode = M_FULL;
          tick();
          req_valid = 1'b0;
          check("R7 request in sleep", {7'd0, req_illegal}, 8'd1);
          check("R7 request in sleep", {6'd0, mode}, {6'd0, M_SLP});
          wake_evt = wake_mask;
          tick();
          wake_evt = '0;
          check_state("R8 wake to prior", fm, fm);
        end
        if (cur == M_DEEP) begin
          wake_mask = '1; wake_evt = '1;
          tick();
          tick();
          check_state("R9 wake ignored", M_DEEP, fm);
          req_valid = 1'b1; req_mode = M_FULL;
          tick();
          req_valid = 1'b0;
          check("R7 request in deep", {7'd0, req_illegal}, 8'd1);
          core_idle = 1'b1;
          tick();
          core_idle = 1'b0;
          check("R9 idle ignored", {6'd0, mode}, {6'd0, M_DEEP});
          wake_evt = '0; rtc_irq = 1'b1;
          tick();
          rtc_irq = 1'b0;
          check("R9 rtc to active", {6'd0, mode}, {6'd0, M_ACT});
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog R1..R10 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule